// File: doc/BRIEF.md
# Debug Suspend Clock-Stop Controller

This controller sits in the wrapper around a CAN protocol core. It parks the core while the CPU is halted for debugging. The halt input is asynchronous, so it passes through a flop synchroniser first. When halt is seen and the suspend-disable setting is clear, the controller asks the core to stop its clock. The core finishes its current work, waits for the bus to go idle, sets its init bit and then acknowledges. No clock is gated here. The host clock and the CAN clock both keep running, so a debugger can still read and write registers and message RAM.

When the halt ends, the debug request drops and the controller waits for the core to release its acknowledge. If auto-wakeup is set, the controller then runs one read-modify-write on the core control register. The write clears only the init bit, and the core returns to operation without help from software. If auto-wakeup is clear, the init bit stays set and software must clear it.

The stop-acknowledge status and the wake interrupt are both gated by the software stop-request setting. A stop caused by debug therefore never shows in that status and never raises the wake interrupt. Register auto-clear is held off while a debug suspend is pending or active. A small configuration register holds the five settings.

Top module: `dbg_susp_ctrl`

## Requirements
- R1: The debug part of the stop request is asserted only while the synchronised halt is high and the suspend-disable field (config bit 0) is 0. With that field at 1, a halt leaves `stop_req_o` equal to the software stop field.
- R2: After reset, the config register holds suspend-disable = 1 and every other field = 0. The fields are: bit 1 auto-wakeup, bit 2 wake-request enable, bit 3 software stop request, bit 4 wake interrupt enable.
- R3: A change on `cpu_halt_i` reaches `stop_req_o` on the third rising clock edge after the change: two synchroniser stages plus the state register.
- R4: `stop_ack_sts_o` equals `stop_ack_i` AND the software stop field. An acknowledge caused only by debug suspend leaves it at 0.
- R5: With auto-wakeup = 1, the acknowledge falling after a halt release starts exactly one read cycle (`ctl_rd_o`) followed by one write cycle (`ctl_wr_o`). The written word equals the read word with bit `INIT_POS` (default 0) cleared.
- R6: With auto-wakeup = 0, no control-register access follows a resume, and the core init bit stays 1.
- R7: While stopped for debug, a wake from the core does not release the stop request. `wake_en_o` mirrors the wake-request-enable field.
- R8: `wake_irq_o` equals the core wake AND the software stop field AND the wake interrupt enable field. It is therefore 0 during a debug-only suspend.
- R9: `autoclr_en_o` is 0 while a debug suspend is pending or active, and 1 otherwise.
- R10: `stop_req_o` is the OR of the debug request and the software stop field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_halt_i | input | 1 | Asynchronous CPU debug-halt |
| cfg_wr_i | input | 1 | Config register write strobe |
| cfg_wdata_i | input | 5 | Config write data (fields as in R2) |
| stop_req_o | output | 1 | Clock-stop request to the core |
| stop_ack_i | input | 1 | Clock-stop acknowledge from the core |
| core_wake_i | input | 1 | Clock-stop wake from the core |
| wake_en_o | output | 1 | Wake-request enable to the core |
| ctl_rd_o | output | 1 | Core control register read strobe |
| ctl_rdata_i | input | CTL_W | Core control register read data |
| ctl_wr_o | output | 1 | Core control register write strobe |
| ctl_wdata_o | output | CTL_W | Core control register write data |
| stop_ack_sts_o | output | 1 | Masked stop-acknowledge status |
| wake_irq_o | output | 1 | Masked wake interrupt |
| autoclr_en_o | output | 1 | Register auto-clear permitted |

## Verification
A state register stuck in the suspend path keeps `autoclr_en_o` low and keeps the stop request high after the halt ends. Both show within three cycles of the halt edge. A lost or doubled resume shows as a wrong count of read and write strobes, or as a control word that still has init set or has other bits changed. The bench checks that word a few cycles after the acknowledge falls. A masking fault shows at once on the status or interrupt output, in the same cycle as the acknowledge or wake input.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef struct packed {
        logic wake_irq_en;
        logic sw_stop;
        logic wake_req_en;
        logic auto_wu;
        logic keep_run;
    } dss_cfg_t;

    localparam int CFG_W = $bits(dss_cfg_t);

    localparam dss_cfg_t CFG_RST = '{
        wake_irq_en: 1'b0,
        sw_stop:     1'b0,
        wake_req_en: 1'b0,
        auto_wu:     1'b0,
        keep_run:    1'b1
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_STOPPED,
        ST_RESUME,
        ST_RMW_RD,
        ST_RMW_WR
    } dss_state_t;

    function automatic logic in_suspend(dss_state_t s);
        return (s == ST_REQ) || (s == ST_STOPPED);
    endfunction

    function automatic logic halt_active(logic halt_s, dss_cfg_t c);
        return halt_s && !c.keep_run;
    endfunction

endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dss_cfg_reg.sv
module dss_cfg_reg
    import dss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output dss_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= CFG_RST;
        else if (wr) cfg <= dss_cfg_t'(wdata);
    end
endmodule

// File: rtl/dss_fsm.sv
module dss_fsm
    import dss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_s,
    input  dss_cfg_t   cfg,
    input  logic       ack,
    output dss_state_t st,
    output logic       dbg_req
);
    dss_state_t st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:    if (halt_active(halt_s, cfg)) st_nx = ST_REQ;
            ST_REQ: begin
                if (!halt_active(halt_s, cfg)) st_nx = ST_IDLE;
                else if (ack)                  st_nx = ST_STOPPED;
            end
            ST_STOPPED: if (!halt_active(halt_s, cfg)) st_nx = ST_RESUME;
            ST_RESUME:  if (!ack) st_nx = cfg.auto_wu ? ST_RMW_RD : ST_IDLE;
            ST_RMW_RD:  st_nx = ST_RMW_WR;
            ST_RMW_WR:  st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign dbg_req = in_suspend(st);
endmodule

// File: rtl/dss_rmw.sv
module dss_rmw #(
    parameter int CTL_W    = 8,
    parameter int INIT_POS = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_phase,
    input  logic [CTL_W-1:0] rdata,
    output logic [CTL_W-1:0] wdata
);
    localparam logic [CTL_W-1:0] INIT_MASK = CTL_W'(1) << INIT_POS;

    logic [CTL_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)           held <= '0;
        else if (rd_phase) held <= rdata;
    end

    assign wdata = held & ~INIT_MASK;
endmodule

// File: rtl/dbg_susp_ctrl.sv
module dbg_susp_ctrl
    import dss_pkg::*;
#(
    parameter int CTL_W       = 8,
    parameter int INIT_POS    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_halt_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             stop_req_o,
    input  logic             stop_ack_i,
    input  logic             core_wake_i,
    output logic             wake_en_o,
    output logic             ctl_rd_o,
    input  logic [CTL_W-1:0] ctl_rdata_i,
    output logic             ctl_wr_o,
    output logic [CTL_W-1:0] ctl_wdata_o,
    output logic             stop_ack_sts_o,
    output logic             wake_irq_o,
    output logic             autoclr_en_o
);
    logic       halt_s;
    dss_cfg_t   cfg;
    dss_state_t st;
    logic       dbg_req;

    dss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(cpu_halt_i), .q(halt_s)
    );

    dss_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr_i), .wdata(cfg_wdata_i), .cfg(cfg)
    );

    dss_fsm u_fsm (
        .clk(clk), .rst(rst), .halt_s(halt_s), .cfg(cfg),
        .ack(stop_ack_i), .st(st), .dbg_req(dbg_req)
    );

    assign ctl_rd_o = (st == ST_RMW_RD);
    assign ctl_wr_o = (st == ST_RMW_WR);

    dss_rmw #(.CTL_W(CTL_W), .INIT_POS(INIT_POS)) u_rmw (
        .clk(clk), .rst(rst), .rd_phase(ctl_rd_o),
        .rdata(ctl_rdata_i), .wdata(ctl_wdata_o)
    );

    assign stop_req_o     = dbg_req | cfg.sw_stop;
    assign wake_en_o      = cfg.wake_req_en;
    assign stop_ack_sts_o = stop_ack_i & cfg.sw_stop;
    assign wake_irq_o     = core_wake_i & cfg.sw_stop & cfg.wake_irq_en;
    assign autoclr_en_o   = !dbg_req;
endmodule

// File: rtl/dss_checker.sv
module dss_checker
    import dss_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       halt_s,
    input dss_cfg_t   cfg,
    input dss_state_t st,
    input logic       dbg_req,
    input logic       stop_ack_i,
    input logic       stop_req_o,
    input logic       ctl_rd_o,
    input logic       ctl_wr_o,
    input logic       wake_irq_o,
    input logic       autoclr_en_o
);
    a_r1_req_needs_halt: assert property (@(posedge clk) disable iff (rst)
        $rose(dbg_req) |-> ($past(halt_s) && !$past(cfg.keep_run)));

    a_r5_wr_follows_rd: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_o |-> $past(ctl_rd_o));

    a_r5_rd_after_ack_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_rd_o) |-> ($past(st) == ST_RESUME && !$past(stop_ack_i)));

    a_r7_wake_holds_stop: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOPPED && halt_s && !cfg.keep_run) |=> stop_req_o);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        wake_irq_o |-> (cfg.sw_stop && cfg.wake_irq_en));

    a_r9_no_autoclr_in_suspend: assert property (@(posedge clk) disable iff (rst)
        ($rose(dbg_req) && !cfg.sw_stop) |-> !autoclr_en_o);
endmodule

bind dbg_susp_ctrl dss_checker u_chk (
    .clk(clk), .rst(rst), .halt_s(halt_s), .cfg(cfg), .st(st),
    .dbg_req(dbg_req), .stop_ack_i(stop_ack_i), .stop_req_o(stop_req_o),
    .ctl_rd_o(ctl_rd_o), .ctl_wr_o(ctl_wr_o), .wake_irq_o(wake_irq_o),
    .autoclr_en_o(autoclr_en_o)
);

// File: tb/dbg_susp_ctrl_test.sv
module dbg_susp_ctrl_test;
    localparam int CW = 8;
    localparam logic [CW-1:0] CTL_INIT = 8'hA4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt = 1'b0, cfg_wr = 1'b0;
    logic [4:0] cfg_wd = '0;
    logic stop_req, ack, core_wake, wake_en, ctl_rd, ctl_wr;
    logic [CW-1:0] ctl_reg, ctl_wdata;
    logic sts, irq, autoclr;
    logic bus_idle = 1'b0, rx = 1'b0;
    int   errors = 0, checks = 0, rd_cnt = 0, wr_cnt = 0;
    logic [4:0] cfg_m = 5'b00001;
    logic done = 1'b0;

    always #5 clk = ~clk;

    dbg_susp_ctrl uut (
        .clk(clk), .rst(rst), .cpu_halt_i(halt), .cfg_wr_i(cfg_wr),
        .cfg_wdata_i(cfg_wd), .stop_req_o(stop_req), .stop_ack_i(ack),
        .core_wake_i(core_wake), .wake_en_o(wake_en), .ctl_rd_o(ctl_rd),
        .ctl_rdata_i(ctl_reg), .ctl_wr_o(ctl_wr), .ctl_wdata_o(ctl_wdata),
        .stop_ack_sts_o(sts), .wake_irq_o(irq), .autoclr_en_o(autoclr)
    );

    // core model: init set once bus idle, then acknowledge
    assign core_wake = ack & wake_en & rx;
    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0; ctl_reg <= CTL_INIT; rd_cnt <= 0; wr_cnt <= 0;
        end else begin
            if (stop_req && bus_idle) ctl_reg[0] <= 1'b1;
            if (stop_req && bus_idle && ctl_reg[0]) ack <= 1'b1;
            else if (!stop_req) ack <= 1'b0;
            if (ctl_wr) begin ctl_reg <= ctl_wdata; wr_cnt <= wr_cnt + 1; end
            if (ctl_rd) rd_cnt <= rd_cnt + 1;
        end
    end

    function automatic logic exp_sts(logic a, logic [4:0] c);
        return a & c[3];
    endfunction
    function automatic logic exp_irq(logic a, logic r, logic [4:0] c);
        return a & c[2] & r & c[3] & c[4];
    endfunction

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcfg(logic [4:0] v);
        cfg_wr = 1'b1; cfg_wd = v; tick(); cfg_wr = 1'b0; cfg_m = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        tick(3); rst = 1'b0; tick();
        // R2 reset state
        chk("R2 stop_req", stop_req, 0);
        chk("R9 autoclr", autoclr, 1);
        chk("R2 wake_en", wake_en, 0);
        halt = 1'b1; tick(6);
        chk("R2 keep_run default blocks R1 request", stop_req, 0);
        halt = 1'b0; tick(4);

        // debug suspend with auto-wakeup
        wcfg(5'b10110);  // irq_en, wake_req_en, auto_wu; keep_run=0
        chk("R7 wake_en mirrors", wake_en, 1);
        halt = 1'b1; tick(2);
        chk("R3 not yet", stop_req, 0);
        tick();
        chk("R3 request on third edge", stop_req, 1);
        chk("R9 autoclr off", autoclr, 0);
        tick(4);
        chk("R1 no ack while bus busy", ack, 0);
        bus_idle = 1'b1; tick(4);
        chk("R1 core acked", ack, 1);
        chk("R4 debug ack hidden", sts, 0);
        rx = 1'b1; tick();
        chk("R8 core wake present", core_wake, 1);
        chk("R8 irq masked", irq, 0);
        tick(8);
        chk("R7 wake keeps request", stop_req, 1);
        rx = 1'b0;
        halt = 1'b0; tick(2);
        chk("R3 release lag", stop_req, 1);
        tick();
        chk("R3 released", stop_req, 0);
        tick(8);
        chk("R5 init cleared, rest kept", ctl_reg, CTL_INIT);
        chk("R5 one read", rd_cnt, 1);
        chk("R5 one write", wr_cnt, 1);
        chk("R9 autoclr back", autoclr, 1);

        // without auto-wakeup
        wcfg(5'b00000);
        halt = 1'b1; tick(10);
        chk("R1 stopped again", ack, 1);
        halt = 1'b0; tick(12);
        chk("R6 init stays set", ctl_reg[0], 1);
        chk("R6 no write", wr_cnt, 1);
        chk("R6 no read", rd_cnt, 1);

        // software stop: status and irq visible
        wcfg(5'b11101);
        tick(4);
        chk("R10 sw stop request", stop_req, 1);
        chk("R4 sts visible", sts, 1);
        rx = 1'b1; tick();
        chk("R8 irq on sw stop", irq, 1);
        rx = 1'b0;
        wcfg(5'b00001); tick(4);

        // random: keep_run held at 1
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            wcfg({r[3:1], 1'b0, 1'b1} | {r[4], 4'b0});
            halt = r[5]; rx = r[6];
            tick(r[8:7] + 1);
            chk("R1/R10 random stop_req", stop_req, cfg_m[3]);
            chk("R4 random sts", sts, exp_sts(ack, cfg_m));
            chk("R8 random irq", irq, exp_irq(ack, rx, cfg_m));
            chk("R7 random wake_en", wake_en, cfg_m[2]);
        end
        chk("R5 no stray write", wr_cnt, 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule